// File: doc/BRIEF.md
# Stereo Channel Routing Mixer

This block sits in front of a stereo DAC and decides what each of the two DAC channels plays. Every audio frame delivers one signed left sample and one signed right sample together with a valid strobe. A 4-bit routing word gives each output its own source. The source can be silence, the left input, the right input, or the mono mix formed as half the sum of the two inputs. Each output is chosen independently, so all sixteen combinations of the two selectors are usable. Examples are a stereo swap, both outputs carrying the mono mix, or one side muted.

The routing word is a plain input port. The register that drives it should reset to the straight-through setting, which the package exports as `ROUTE_DEFAULT` (binary 1001). The word is sampled only in the cycle that carries the input strobe. Both outputs of one frame are therefore always built from the same setting, and the new outputs appear one clock later with their own one-cycle strobe. Between strobes the outputs hold their last frame.

Top module: `mix_route`

## Requirements
- R1: Bits [1:0] of `route` pick the left output: 00 silence, 01 left input, 10 right input, 11 mono mix.
- R2: Bits [3:2] of `route` pick the right output using the same encoding: 00 silence, 01 left input, 10 right input, 11 mono mix.
- R3: All sixteen `route` values are legal, and the two fields act independently of each other.
- R4: The package constant `ROUTE_DEFAULT` equals 4'b1001 and, applied to `route`, sends the left input to `out_l` and the right input to `out_r`.
- R5: The mono mix equals floor((L+R)/2), computed with one guard bit. It never overflows, even when both inputs are at full-scale positive or full-scale negative.
- R6: Silence is an exact all-zero sample.
- R7: When `in_valid` is high at a rising edge, `out_l` and `out_r` take the new values at that edge, and `out_valid` is high for exactly the following cycle. `out_valid` is low in every other cycle.
- R8: `route`, `in_l` and `in_r` are sampled only with `in_valid`. Changes to them between strobes leave `out_l` and `out_r` unchanged.
- R9: While `rst_n` is low, `out_l` and `out_r` are zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input frame strobe |
| in_l | input | W | Left input sample, two's complement |
| in_r | input | W | Right input sample, two's complement |
| route | input | 4 | Routing word: [1:0] selects the left output, [3:2] selects the right output |
| out_valid | output | 1 | Output frame strobe |
| out_l | output | W | Left output sample |
| out_r | output | W | Right output sample |

## Verification
The bench builds the block with W=8. With that width, uniform random samples land on the full-scale codes -128 and 127 and on odd sums often, so the guard bit and the floor rounding of the mono mix get regular use. Directed frames pin down the extremes of the mix and walk all sixteen routing words. Back-to-back strobes and quiet gaps with changing inputs exercise the strobe timing and the hold behaviour.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int FIELD_W = 2;
  localparam int ROUTE_W = 2 * FIELD_W;

  typedef enum logic [FIELD_W-1:0] {
    SRC_MUTE  = 2'b00,
    SRC_LEFT  = 2'b01,
    SRC_RIGHT = 2'b10,
    SRC_MONO  = 2'b11
  } route_src_e;

  // straight-through: left field = SRC_LEFT, right field = SRC_RIGHT
  localparam logic [ROUTE_W-1:0] ROUTE_DEFAULT = {SRC_RIGHT, SRC_LEFT};
endpackage

// File: rtl/mix_avg.sv
module mix_avg #(
  parameter int W = 24
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam int SW = W + 1;

  logic signed [SW-1:0] sum;
  logic signed [W-1:0]  lo;
  logic signed [W-1:0]  hi;

  always_comb begin
    sum = {a[W-1], a} + {b[W-1], b};
    y   = sum[SW-1:1];
  end

  // mix must lie between the two operands (no wrap)
  always_comb begin
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    p_avg_bound_r5: assert (y >= lo && y <= hi);
  end
endmodule

// File: rtl/mix_chan_sel.sv
module mix_chan_sel
  import mix_pkg::*;
#(
  parameter int W = 24
) (
  input  route_src_e          sel,
  input  logic signed [W-1:0] src_l,
  input  logic signed [W-1:0] src_r,
  input  logic signed [W-1:0] src_mono,
  output logic signed [W-1:0] y
);
  always_comb begin
    unique case (sel)
      SRC_MUTE:  y = '0;
      SRC_LEFT:  y = src_l;
      SRC_RIGHT: y = src_r;
      SRC_MONO:  y = src_mono;
      default:   y = '0;
    endcase
  end
endmodule

// File: rtl/mix_route.sv
module mix_route
  import mix_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic signed [W-1:0]       in_l,
  input  logic signed [W-1:0]       in_r,
  input  logic [ROUTE_W-1:0]        route,
  output logic                      out_valid,
  output logic signed [W-1:0]       out_l,
  output logic signed [W-1:0]       out_r
);
  localparam int NCH = ROUTE_W / FIELD_W;

  logic signed [W-1:0] mono;
  logic signed [W-1:0] pick   [NCH];
  logic signed [W-1:0] smp_d  [NCH];
  logic signed [W-1:0] smp_q  [NCH];
  logic                vld_d;
  logic                vld_q;

  mix_avg #(.W(W)) i_avg (
    .a (in_l),
    .b (in_r),
    .y (mono)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    mix_chan_sel #(.W(W)) i_sel (
      .sel      (route_src_e'(route[FIELD_W*g +: FIELD_W])),
      .src_l    (in_l),
      .src_r    (in_r),
      .src_mono (mono),
      .y        (pick[g])
    );

    always_comb begin
      smp_d[g] = in_valid ? pick[g] : smp_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smp_q[g] <= '0;
      else        smp_q[g] <= smp_d[g];
    end
  end

  always_comb vld_d = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign out_valid = vld_q;
  assign out_l     = smp_q[0];
  assign out_r     = smp_q[NCH-1];

  p_strobe_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_strobe_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(out_l) && $stable(out_r)));
  p_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && route[1:0] == 2'b00) |=> out_l == '0);
  p_left_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && route[1:0] == 2'b01) |=> out_l == $past(in_l));
  p_right_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && route[3:2] == 2'b10) |=> out_r == $past(in_r));
endmodule

// File: tb/test_mix_route.sv
module test_mix_route;
  import mix_pkg::*;

  localparam int W = 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic signed [W-1:0] in_l = '0;
  logic signed [W-1:0] in_r = '0;
  logic [3:0]          route = 4'b0000;
  logic                out_valid;
  logic signed [W-1:0] out_l;
  logic signed [W-1:0] out_r;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  mix_route #(.W(W)) i_mix_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_l      (in_l),
    .in_r      (in_r),
    .route     (route),
    .out_valid (out_valid),
    .out_l     (out_l),
    .out_r     (out_r)
  );

  function automatic logic signed [W-1:0] exp_pick(input logic [1:0] s,
      input logic signed [W-1:0] l, input logic signed [W-1:0] r);
    int sm;
    sm = int'(l) + int'(r);
    case (s)
      2'b00:   return '0;
      2'b01:   return l;
      2'b10:   return r;
      default: return W'(sm >>> 1);
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one frame; samples right after the capturing edge
  task automatic frame(input logic signed [W-1:0] l, input logic signed [W-1:0] r,
                       input logic [3:0] rt, input string req);
    @(negedge clk);
    in_l = l; in_r = r; route = rt; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " out_l"}, int'(out_l), int'(exp_pick(rt[1:0], l, r)));
    check({req, " out_r"}, int'(out_r), int'(exp_pick(rt[3:2], l, r)));
    check({req, " out_valid"}, int'(out_valid), 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic signed [W-1:0] hl, hr;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 out_l", int'(out_l), 0);
    check("R9 out_r", int'(out_r), 0);
    check("R9 out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 default routing
    check("R4 const", int'(ROUTE_DEFAULT), 9);
    frame(8'sd37, -8'sd90, ROUTE_DEFAULT, "R4");
    @(negedge clk);
    check("R7 strobe drop", int'(out_valid), 0);

    // R1 / R2 / R6 individual fields
    frame(8'sd11, 8'sd22, 4'b0001, "R1 left src");
    frame(8'sd11, 8'sd22, 4'b0010, "R1 right src");
    frame(8'sd11, 8'sd22, 4'b0100, "R2 left src");
    frame(8'sd11, 8'sd22, 4'b1000, "R2 right src");
    frame(-8'sd5, 8'sd100, 4'b0000, "R6 mute");

    // R5 mix extremes and rounding
    frame(8'sd127, 8'sd127, 4'b1111, "R5 pos full");
    frame(-8'sd128, -8'sd128, 4'b1111, "R5 neg full");
    frame(-8'sd1, 8'sd0, 4'b1111, "R5 floor");
    frame(8'sd127, -8'sd128, 4'b1111, "R5 span");

    // R3 every routing word
    for (int k = 0; k < 16; k++) frame(-8'sd77, 8'sd45, 4'(k), "R3 sweep");

    // R7 back-to-back strobes
    @(negedge clk);
    in_l = 8'sd3; in_r = 8'sd4; route = 4'b0110; in_valid = 1'b1;
    @(negedge clk);
    check("R7 b2b first l", int'(out_l), 4);
    check("R7 b2b first v", int'(out_valid), 1);
    in_l = -8'sd9; in_r = 8'sd50; route = 4'b1101;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 b2b second l", int'(out_l), int'(exp_pick(2'b01, -8'sd9, 8'sd50)));
    check("R7 b2b second r", int'(out_r), int'(exp_pick(2'b11, -8'sd9, 8'sd50)));
    check("R7 b2b second v", int'(out_valid), 1);

    // R8 inputs change without a strobe
    hl = out_l; hr = out_r;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_l = W'($urandom); in_r = W'($urandom); route = 4'($urandom);
    end
    @(negedge clk);
    check("R8 hold l", int'(out_l), int'(hl));
    check("R8 hold r", int'(out_r), int'(hr));
    check("R8 no strobe", int'(out_valid), 0);

    // random frames, R3 / R5 mixed, with random gaps
    for (int k = 0; k < 400; k++) begin
      frame(W'($urandom), W'($urandom), 4'($urandom), "R3 random");
      repeat ($urandom % 3) @(negedge clk);
    end

    // R9 reset mid-run
    frame(8'sd60, 8'sd61, 4'b0101, "R9 pre");
    #1 rst_n = 1'b0;
    #1;
    check("R9 async l", int'(out_l), 0);
    check("R9 async v", int'(out_valid), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule